// File: doc/BRIEF.md
# Memory-Mapped Terminal Controller

This block lets a processor drive a character terminal through four 32-bit registers placed in a reserved window at the top of the address space. Incoming keyboard characters arrive on a byte-valid strobe and are captured into a receive register. Outgoing characters written by software are presented to a display sink through a valid/ready stream. Each direction has a control register and a data register. The control register carries a Ready flag, an Interrupt Enable flag and, on the receive side, an overrun flag.

Software either polls the Ready flags or enables interrupts. A direction requests service while its enable and Ready flags are both set, and the single `irq` output is the OR of the two requests. The receive input has no back-pressure: every strobe is accepted. The transmit output holds `tx_valid` and `tx_char` steady until the sink raises `tx_ready`. A sink that is still busy with a character keeps `tx_ready` low, and this stalls the transmitter's Ready flag.

Top module: `term_mmio`

## Requirements
- R1: After reset, receive Ready, both interrupt enables and the overrun flag are 0, transmit Ready is 1, `tx_valid` and `irq` are 0, and `bus_rdata` is 0.
- R2: With base address 0xFFFF0000, the word offsets are 0x0 for receive control, 0x4 for receive data, 0x8 for transmit control and 0xC for transmit data. Any other address, including a misaligned one inside the window, reads as zero, and a write to it changes nothing.
- R3: A cycle with `rx_valid` high stores `rx_char` and sets receive Ready (control bit 0). The receive data register returns the last stored character in bits 7:0 and zero in bits 31:8.
- R4: A read of the receive data register clears receive Ready and the overrun flag. If a new character arrives in that same cycle, the read returns the old character, Ready stays 1 and overrun stays 0.
- R5: A character that arrives while receive Ready is 1, with no read of the data register in that cycle, overwrites the stored character and sets the overrun flag (control bit 2).
- R6: In both control registers, bit 1 is the interrupt enable. It is written only when byte strobe 0 is set. Bit 0 (Ready) ignores writes, and bits 31:3 read as zero (bit 2 is also zero on the transmit side).
- R7: A write to the transmit data register with byte strobe 0 set, while transmit Ready is 1, puts bits 7:0 on `tx_char`, raises `tx_valid` and clears transmit Ready from the next cycle on.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_char` hold. After a cycle with both high, `tx_valid` is 0 and transmit Ready is 1.
- R9: A write to the transmit data register is ignored while transmit Ready is 0, and also when byte strobe 0 is clear.
- R10: `irq` is high exactly when (receive enable AND receive Ready) OR (transmit enable AND transmit Ready).
- R11: A read (`bus_rd` high) returns, in `bus_rdata` after the next clock edge, the register value as it stood in the read cycle. `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Keyboard character strobe |
| rx_char | input | 8 | Keyboard character |
| tx_valid | output | 1 | Display character pending |
| tx_char | output | 8 | Display character |
| tx_ready | input | 1 | Display sink accepts the pending character |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a keyboard character that lands in the same cycle as a read of the receive data register. That case decides whether the overrun flag and the Ready flag resolve correctly. The bench raises `rx_valid` and the data read on the same falling edge as a directed case. A seeded random phase then interleaves arrivals, data reads, control reads and enable writes, so that overruns, back-to-back reads and interrupt toggles occur in many orders. On the transmit side, the sink stalls for several programmed delays while software writes into the busy transmitter.

// File: rtl/term_pkg.sv
package term_pkg;
  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } term_reg_e;

  localparam int unsigned NUM_REGS  = 4;
  localparam int unsigned BIT_READY = 0;
  localparam int unsigned BIT_IE    = 1;
  localparam int unsigned BIT_OVR   = 2;
  localparam int unsigned CTRL_BITS = 3;
endpackage

// File: rtl/term_addr_dec.sv
module term_addr_dec #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NREGS = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [NREGS-1:0]  sel
);
  localparam int unsigned IDX_W = $clog2(NREGS);
  localparam int unsigned LSB_W = 2;
  localparam int unsigned TOP_LSB = IDX_W + LSB_W;

  logic             win_match;
  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign win_match = (addr[ADDR_W-1:TOP_LSB] == BASE_ADDR[ADDR_W-1:TOP_LSB]);
  assign aligned   = (addr[LSB_W-1:0] == '0);
  assign idx       = addr[TOP_LSB-1:LSB_W];
  assign hit       = win_match && aligned;

  for (genvar g = 0; g < NREGS; g++) begin : g_sel
    assign sel[g] = hit && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              rd_data,
  input  logic              ctrl_we,
  input  logic              ctrl_ie_wr,
  output logic              ready,
  output logic              ie,
  output logic              overrun,
  output logic [CHAR_W-1:0] char_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      ie      <= 1'b0;
      overrun <= 1'b0;
      char_q  <= '0;
    end else begin
      if (in_valid) char_q <= in_char;
      ready   <= in_valid | (ready & ~rd_data);
      overrun <= (in_valid & ready & ~rd_data) | (overrun & ~rd_data);
      if (ctrl_we) ie <= ctrl_ie_wr;
    end
  end

  assign irq = ie & ready;

  assert_set_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (ready && char_q == $past(in_char)));
  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !in_valid) |=> (!ready && !overrun));
  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready && !rd_data) |=> overrun);
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [CHAR_W-1:0] data_char,
  input  logic              ctrl_we,
  input  logic              ctrl_ie_wr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              ready,
  output logic              ie,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b1;
      out_valid <= 1'b0;
      out_char  <= '0;
      ie        <= 1'b0;
    end else begin
      if (data_we && ready) begin
        out_char  <= data_char;
        out_valid <= 1'b1;
        ready     <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        ready     <= 1'b1;
      end
      if (ctrl_we) ie <= ctrl_ie_wr;
    end
  end

  assign irq = ie & ready;

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && ready) |=> (out_valid && !ready && out_char == $past(data_char)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (ready && !out_valid));
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ready && !out_ready) |=> $stable(out_char));
endmodule

// File: rtl/term_mmio.sv
module term_mmio #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                rx_valid,
  input  logic [CHAR_W-1:0]   rx_char,
  output logic                tx_valid,
  output logic [CHAR_W-1:0]   tx_char,
  input  logic                tx_ready,
  output logic                irq
);
  import term_pkg::*;

  localparam int unsigned STRB_W = DATA_W / 8;

  logic                hit;
  logic [NUM_REGS-1:0] sel;
  logic                rx_ready, rx_ie, rx_ovr, rx_irq;
  logic [CHAR_W-1:0]   rx_q;
  logic                tx_rdy, tx_ie, tx_irq;
  logic                lane0_wr;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_bits;

  term_addr_dec #(.ADDR_W(ADDR_W), .NREGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) dec_i (
    .addr(bus_addr), .hit(hit), .sel(sel)
  );

  assign lane0_wr = bus_wr && bus_wstrb[0];

  term_rx_chan #(.CHAR_W(CHAR_W)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_char(rx_char),
    .rd_data(bus_rd && sel[REG_RX_DATA]),
    .ctrl_we(lane0_wr && sel[REG_RX_CTRL]),
    .ctrl_ie_wr(bus_wdata[BIT_IE]),
    .ready(rx_ready), .ie(rx_ie), .overrun(rx_ovr),
    .char_q(rx_q), .irq(rx_irq)
  );

  term_tx_chan #(.CHAR_W(CHAR_W)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .data_we(lane0_wr && sel[REG_TX_DATA]),
    .data_char(bus_wdata[CHAR_W-1:0]),
    .ctrl_we(lane0_wr && sel[REG_TX_CTRL]),
    .ctrl_ie_wr(bus_wdata[BIT_IE]),
    .out_ready(tx_ready), .out_valid(tx_valid), .out_char(tx_char),
    .ready(tx_rdy), .ie(tx_ie), .irq(tx_irq)
  );

  assign irq = rx_irq | tx_irq;
  assign unused_bits = ^{bus_wdata[DATA_W-1:CHAR_W], bus_wstrb[STRB_W-1:1]};

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel[REG_RX_CTRL]: rd_mux = {{(DATA_W-CTRL_BITS){1'b0}}, rx_ovr, rx_ie, rx_ready};
      sel[REG_RX_DATA]: rd_mux = {{(DATA_W-CHAR_W){1'b0}}, rx_q};
      sel[REG_TX_CTRL]: rd_mux = {{(DATA_W-CTRL_BITS){1'b0}}, 1'b0, tx_ie, tx_rdy};
      sel[REG_TX_DATA]: rd_mux = '0;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0));
  assert_ctrl_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel[REG_RX_CTRL] || sel[REG_TX_CTRL])) |=> (bus_rdata[DATA_W-1:CTRL_BITS] == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  assert_irq_needs_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ready || tx_rdy));
  always_comb begin
    assert_onehot_sel_R2: assert ($onehot0(sel));
  end
endmodule

// File: tb/term_mmio_tb.sv
`timescale 1ns/1ps
module term_mmio_tb_top;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_char = '0;
  logic tx_valid;
  logic [7:0] tx_char;
  logic tx_ready = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_rx_ready = 0, m_rx_ie = 0, m_ovr = 0, m_tx_ready = 1, m_tx_ie = 0;
  logic [7:0] m_rx_char = '0;

  always #2 clk = ~clk;

  term_mmio dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_char(rx_char), .tx_valid(tx_valid), .tx_char(tx_char),
    .tx_ready(tx_ready), .irq(irq)
  );

  function automatic logic [31:0] f_rx_ctrl();
    return {29'd0, m_ovr, m_rx_ie, m_rx_ready};
  endfunction
  function automatic logic [31:0] f_tx_ctrl();
    return {30'd0, m_tx_ie, m_tx_ready};
  endfunction
  function automatic logic f_irq();
    return (m_rx_ie & m_rx_ready) | (m_tx_ie & m_tx_ready);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rx_send(input logic [7:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
    if (m_rx_ready) m_ovr = 1'b1;
    m_rx_ready = 1'b1; m_rx_char = c;
  endtask

  task automatic read_rx_data(input string req);
    logic [31:0] d;
    bus_read(A_RXD, d);
    chk(req, d, {24'd0, m_rx_char});
    m_rx_ready = 1'b0; m_ovr = 1'b0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata", bus_rdata, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(A_RXC, d); chk("R1 rx ctrl", d, 32'h0);
    bus_read(A_TXC, d); chk("R1 tx ctrl", d, 32'h1);

    // R11: rdata holds without a read
    @(negedge clk); chk("R11 hold", bus_rdata, 32'h1);

    // R3: receive and format
    rx_send(8'hA5);
    bus_read(A_RXC, d); chk("R3 ready set", d, f_rx_ctrl());
    read_rx_data("R3 data format");
    bus_read(A_RXC, d); chk("R4 ready cleared", d, f_rx_ctrl());

    // R5: overrun then cleared by data read (R4)
    rx_send(8'h11);
    rx_send(8'h22);
    bus_read(A_RXC, d); chk("R5 overrun", d, 32'h5);
    read_rx_data("R5 overwritten char");
    bus_read(A_RXC, d); chk("R4 overrun cleared", d, 32'h0);

    // R4: arrival in the same cycle as data read
    rx_send(8'h33);
    bus_addr = A_RXD; bus_rd = 1'b1; rx_valid = 1'b1; rx_char = 8'h44;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    chk("R4 same-cycle old char", bus_rdata, 32'h33);
    m_rx_char = 8'h44; m_rx_ready = 1'b1; m_ovr = 1'b0;
    bus_read(A_RXC, d); chk("R4 same-cycle ready kept", d, 32'h1);
    read_rx_data("R4 same-cycle new char");

    // R6: ready read-only, IE lane 0 only
    bus_write(A_RXC, 32'hFFFF_FFFD, 4'hF);
    bus_read(A_RXC, d); chk("R6 ready read-only", d, 32'h0);
    bus_write(A_RXC, 32'h0000_0002, 4'hE);
    bus_read(A_RXC, d); chk("R6 lane0 needed", d, 32'h0);
    bus_write(A_RXC, 32'h0000_0002, 4'h1); m_rx_ie = 1'b1;
    bus_read(A_RXC, d); chk("R6 ie set", d, 32'h2);

    // R10: irq follows enable and ready
    chk("R10 irq off", {31'd0, irq}, {31'd0, f_irq()});
    rx_send(8'h5A);
    chk("R10 irq rx", {31'd0, irq}, 32'd1);
    read_rx_data("R10 drain");
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R2: unmapped and misaligned accesses
    bus_read(BASE + 32'h10, d); chk("R2 past window", d, 32'h0);
    bus_read(32'h0000_0004, d); chk("R2 low addr", d, 32'h0);
    bus_read(BASE + 32'h2, d); chk("R2 misaligned", d, 32'h0);
    bus_write(BASE + 32'h1A, 32'hFFFF_FFFF, 4'hF);
    bus_write(BASE + 32'h9, 32'h0, 4'hF);
    bus_read(A_RXC, d); chk("R2 write ignored rx", d, f_rx_ctrl());
    bus_read(A_TXC, d); chk("R2 write ignored tx", d, f_tx_ctrl());
    chk("R2 no tx", {31'd0, tx_valid}, 32'd0);

    // R9: transmit write without lane 0 strobe
    bus_write(A_TXD, 32'h0000_0077, 4'hE);
    chk("R9 no lane0", {31'd0, tx_valid}, 32'd0);

    // R7/R8/R9: transmit with stalling sink
    bus_write(A_TXC, 32'h2, 4'h1); m_tx_ie = 1'b1;
    chk("R10 tx irq", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      int n;
      logic [7:0] c;
      n = (k == 0) ? 0 : (k == 1 ? 3 : 7);
      c = 8'h41 + 8'(k);
      tx_ready = 1'b0;
      bus_write(A_TXD, {24'hABCDEF, c}, 4'h1); m_tx_ready = 1'b0;
      chk("R7 valid", {31'd0, tx_valid}, 32'd1);
      chk("R7 char", {24'd0, tx_char}, {24'd0, c});
      chk("R10 tx busy irq", {31'd0, irq}, {31'd0, f_irq()});
      bus_read(A_TXC, d); chk("R7 ready cleared", d, f_tx_ctrl());
      bus_write(A_TXD, 32'h0000_0099, 4'hF);
      chk("R9 busy write dropped", {24'd0, tx_char}, {24'd0, c});
      for (int j = 0; j < n; j++) begin
        @(negedge clk);
        chk("R8 hold", {23'd0, tx_valid, tx_char}, {23'd0, 1'b1, c});
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0; m_tx_ready = 1'b1;
      chk("R8 released", {31'd0, tx_valid}, 32'd0);
      bus_read(A_TXC, d); chk("R8 ready back", d, f_tx_ctrl());
      chk("R10 tx irq back", {31'd0, irq}, {31'd0, f_irq()});
    end
    bus_write(A_TXC, 32'h0, 4'h1); m_tx_ie = 1'b0;

    // Random receive/control traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] w;
      op = int'($urandom % 5);
      case (op)
        0, 1: rx_send(8'($urandom));
        2: read_rx_data("R3 random data");
        3: begin bus_read(A_RXC, d); chk("R5 random ctrl", d, f_rx_ctrl()); end
        default: begin
          w = $urandom;
          if (w[4]) begin
            bus_write(A_RXC, w, 4'hF); m_rx_ie = w[1];
          end else begin
            bus_write(A_RXC, w, 4'hE);
          end
        end
      endcase
      chk("R10 random irq", {31'd0, irq}, {31'd0, f_irq()});
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule